// File: doc/BRIEF.md
# Parallel Port Control Register

This block holds the host-visible control byte of an IEEE 1284 style parallel port. Software writes it over a small register bus. The block turns its fields into the port's control pins, with some of them inverted. It also selects whether the data lines are driven or sampled, using the current port mode and, in one mode, the kind of register access in progress.

The block latches two interrupt sources. The first is a rising edge on the peripheral's acknowledge line. That line is resynchronised inside the block before the edge is detected. The second is a time-out of an EPP data or address cycle. Each source has its own enable sense. Each latched status bit stays set until a write-one-to-clear strobe removes it. A single interrupt line reports whether any status bit is pending.

Top module: `pport_ctl_top`

## Requirements
- R1: The control byte sits at bus address 2; a write there stores all 8 bits and a read there returns them on `bus_rdata`; a read at any other address returns 0, and a write at any other address leaves the byte unchanged.
- R2: After reset the control byte reads 0x4C (bits 6, 3 and 2 set, all others clear).
- R3: Pin mapping: `strobe_n` = NOT bit 0, `autofeed_n` = NOT bit 1, `init_n` = bit 2, `select_in_n` = NOT bit 3, `host_hi` = bit 7.
- R4: In modes 3'b001 and 3'b011, `data_oe` (1 = port drives the data lines) is the inverse of bit 5 (bit 5 = 0 means output).
- R5: In modes 3'b000 and 3'b010, `data_oe` is 1 whatever the values of bit 5 and `epp_is_read`.
- R6: In mode 3'b100, `data_oe` is the inverse of `epp_is_read` (a write access drives, a read access samples), and bit 5 has no effect.
- R7: In modes 3'b101, 3'b110 and 3'b111, `data_oe` is 0.
- R8: While bit 4 (acknowledge interrupt enable) is set, a low-to-high change of `ack_n_in` sets `irq_status[0]` at the third rising clock edge after the input change. Edges that arrive while bit 4 is clear, and falling edges, never set it.
- R9: A one-cycle pulse on `epp_timeout` sets `irq_status[1]` at the next clock edge when bit 6 (time-out mask) is clear, and is ignored when bit 6 is set.
- R10: A status bit stays set until a cycle with the matching bit of `irq_clr` at 1 (bit 0 for acknowledge, bit 1 for time-out). A new event in the same cycle as its clear keeps the bit set.
- R11: `irq_out` is 1 exactly when at least one bit of `irq_status` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address for read and write |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| mode_sel | input | 3 | Port mode from the extended control register |
| epp_is_read | input | 1 | Current EPP access is a read (1) or a write (0) |
| ack_n_in | input | 1 | Asynchronous acknowledge line from the peripheral |
| epp_timeout | input | 1 | One-cycle EPP transfer time-out pulse |
| irq_clr | input | 2 | Write-one-to-clear strobes for the status bits |
| strobe_n | output | 1 | Strobe pin, active low |
| autofeed_n | output | 1 | Auto-feed pin, active low |
| init_n | output | 1 | Initialise pin, active low |
| select_in_n | output | 1 | Select-in pin, active low |
| host_hi | output | 1 | Host-logic-high pin |
| data_oe | output | 1 | 1 when the port drives the data lines |
| irq_status | output | 2 | Latched status: bit 0 acknowledge, bit 1 time-out |
| irq_out | output | 1 | OR of the status bits |

## Verification
The assertions assume three things about the inputs. `epp_timeout` and `irq_clr` are synchronous to `clk`. `bus_wdata` and `bus_addr` are stable across the sampling edge of a write. `ack_n_in` holds each level for at least three clocks, so the synchroniser never misses an edge. The stimulus drives every input on the falling clock edge and holds each acknowledge level for at least four cycles. Time-out and clear strobes each last exactly one cycle, so every event the assertions relate is seen once and only once.

// File: rtl/pport_ctl_pkg.sv
package pport_ctl_pkg;

  localparam int unsigned CTL_W = 8;

  // Field positions inside the control byte
  localparam int unsigned B_STROBE  = 0;
  localparam int unsigned B_AUTOFD  = 1;
  localparam int unsigned B_INIT    = 2;
  localparam int unsigned B_SELIN   = 3;
  localparam int unsigned B_ACK_EN  = 4;
  localparam int unsigned B_DIR     = 5;
  localparam int unsigned B_TO_MASK = 6;
  localparam int unsigned B_HOSTHI  = 7;

  localparam int unsigned IRQ_N   = 2;
  localparam int unsigned IRQ_ACK = 0;
  localparam int unsigned IRQ_TO  = 1;

  typedef enum logic [2:0] {
    PM_COMPAT = 3'b000,
    PM_BIDIR  = 3'b001,
    PM_FIFO   = 3'b010,
    PM_EXTCAP = 3'b011,
    PM_EPP    = 3'b100,
    PM_RSV5   = 3'b101,
    PM_RSV6   = 3'b110,
    PM_RSV7   = 3'b111
  } pm_mode_e;

endpackage

// File: rtl/pport_ctl_regfile.sv
module pport_ctl_regfile
  import pport_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned CTRL_ADDR = 2,
  parameter logic [CTL_W-1:0] RST_VAL = 8'h4C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [CTL_W-1:0]  wdata_i,
  output logic [CTL_W-1:0]  rdata_o,
  output logic [CTL_W-1:0]  ctl_q_o
);

  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CTRL_ADDR);

  logic             hit;
  logic             ctl_en;
  logic [CTL_W-1:0] ctl_d;
  logic [CTL_W-1:0] ctl_q;

  always_comb begin
    hit    = (addr_i == SEL);
    ctl_en = wr_en_i && hit;
    ctl_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= RST_VAL;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    rdata_o = hit ? ctl_q : '0;
    ctl_q_o = ctl_q;
  end

  // Write at the control address lands one edge later
  p_wr_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (addr_i == SEL)) |=> (ctl_q_o == $past(wdata_i)));

  // Writes aimed elsewhere leave the byte alone
  p_wr_other_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (addr_i != SEL)) |=> $stable(ctl_q_o));

endmodule

// File: rtl/pport_ctl_dir.sv
module pport_ctl_dir
  import pport_ctl_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       dir_bit_i,
  input  logic       epp_is_read_i,
  output logic       data_oe_o
);

  pm_mode_e mode;

  always_comb begin
    mode = pm_mode_e'(mode_i);
    unique case (mode)
      PM_COMPAT, PM_FIFO:  data_oe_o = 1'b1;
      PM_BIDIR, PM_EXTCAP: data_oe_o = ~dir_bit_i;
      PM_EPP:              data_oe_o = ~epp_is_read_i;
      default:             data_oe_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pport_ctl_irq.sv
module pport_ctl_irq
  import pport_ctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_n_i,
  input  logic             ack_en_i,
  input  logic             to_mask_i,
  input  logic             epp_to_i,
  input  logic [IRQ_N-1:0] clr_i,
  output logic [IRQ_N-1:0] sts_o,
  output logic             irq_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   ack_prev_q;
  logic                   ack_rise;
  logic [IRQ_N-1:0]       evt;
  logic [IRQ_N-1:0]       sts_d;
  logic [IRQ_N-1:0]       sts_q;

  // Synchroniser chain, idle level high
  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], ack_n_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '1;
      ack_prev_q <= 1'b1;
    end else begin
      sync_q     <= sync_d;
      ack_prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    ack_rise     = sync_q[SYNC_STAGES-1] & ~ack_prev_q;
    evt[IRQ_ACK] = ack_rise & ack_en_i;
    evt[IRQ_TO]  = epp_to_i & ~to_mask_i;
  end

  // Per-source sticky status, set beats clear
  for (genvar g = 0; g < IRQ_N; g++) begin : g_sts
    always_comb begin
      sts_d[g] = evt[g] | (sts_q[g] & ~clr_i[g]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sts_q[g] <= 1'b0;
      end else begin
        sts_q[g] <= sts_d[g];
      end
    end
  end

  always_comb begin
    sts_o = sts_q;
    irq_o = |sts_q;
  end

  p_ack_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_o[IRQ_ACK]) |-> $past(ack_en_i));

  p_to_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_o[IRQ_TO]) |-> $past(epp_to_i && !to_mask_i));

  p_ack_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_o[IRQ_ACK] && !clr_i[IRQ_ACK]) |=> sts_o[IRQ_ACK]);

  p_to_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_o[IRQ_TO] && !clr_i[IRQ_TO]) |=> sts_o[IRQ_TO]);

endmodule

// File: rtl/pport_ctl_top.sv
module pport_ctl_top
  import pport_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned CTRL_ADDR   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [2:0]        mode_sel,
  input  logic              epp_is_read,
  input  logic              ack_n_in,
  input  logic              epp_timeout,
  input  logic [1:0]        irq_clr,
  output logic              strobe_n,
  output logic              autofeed_n,
  output logic              init_n,
  output logic              select_in_n,
  output logic              host_hi,
  output logic              data_oe,
  output logic [1:0]        irq_status,
  output logic              irq_out
);

  // Reset asserted asynchronously, released on a clock edge
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
    end
  end

  always_comb rst_int_n = rst_sync_q[RST_STAGES-1];

  logic [CTL_W-1:0] ctl_q;

  pport_ctl_regfile #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .RST_VAL   (8'h4C)
  ) regfile_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .addr_i  (bus_addr),
    .wr_en_i (bus_wr_en),
    .wdata_i (bus_wdata),
    .rdata_o (bus_rdata),
    .ctl_q_o (ctl_q)
  );

  pport_ctl_dir dir_i (
    .mode_i        (mode_sel),
    .dir_bit_i     (ctl_q[B_DIR]),
    .epp_is_read_i (epp_is_read),
    .data_oe_o     (data_oe)
  );

  pport_ctl_irq #(
    .SYNC_STAGES (SYNC_STAGES)
  ) irq_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ack_n_i   (ack_n_in),
    .ack_en_i  (ctl_q[B_ACK_EN]),
    .to_mask_i (ctl_q[B_TO_MASK]),
    .epp_to_i  (epp_timeout),
    .clr_i     (irq_clr),
    .sts_o     (irq_status),
    .irq_o     (irq_out)
  );

  always_comb begin
    strobe_n    = ~ctl_q[B_STROBE];
    autofeed_n  = ~ctl_q[B_AUTOFD];
    init_n      =  ctl_q[B_INIT];
    select_in_n = ~ctl_q[B_SELIN];
    host_hi     =  ctl_q[B_HOSTHI];
  end

endmodule

// File: tb/pport_ctl_tb.sv
module pport_ctl_top_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd2;
  logic       bus_wr_en = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [2:0] mode_sel = 3'b000;
  logic       epp_is_read = 1'b0;
  logic       ack_n_in = 1'b1;
  logic       epp_timeout = 1'b0;
  logic [1:0] irq_clr = 2'b00;
  logic strobe_n, autofeed_n, init_n, select_in_n, host_hi, data_oe, irq_out;
  logic [1:0] irq_status;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pport_ctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_sel(mode_sel),
    .epp_is_read(epp_is_read), .ack_n_in(ack_n_in), .epp_timeout(epp_timeout),
    .irq_clr(irq_clr), .strobe_n(strobe_n), .autofeed_n(autofeed_n),
    .init_n(init_n), .select_in_n(select_in_n), .host_hi(host_hi),
    .data_oe(data_oe), .irq_status(irq_status), .irq_out(irq_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    bus_addr  = 3'd2;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins_chk(input logic [7:0] v);
    chk("R3 strobe_n",    strobe_n,    !v[0]);
    chk("R3 autofeed_n",  autofeed_n,  !v[1]);
    chk("R3 init_n",      init_n,      v[2]);
    chk("R3 select_in_n", select_in_n, !v[3]);
    chk("R3 host_hi",     host_hi,     v[7]);
  endtask

  task automatic ack_pulse();
    ack_n_in = 1'b0;
    cyc(4);
    ack_n_in = 1'b1;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R2: reset value and resulting pins
    chk("R2 reset byte", bus_rdata, 8'h4C);
    pins_chk(8'h4C);
    chk("R11 reset irq_out", irq_out, 0);
    chk("R8 reset status", irq_status, 0);

    // R1/R3: every byte value written and read back
    for (int v = 0; v < 256; v++) begin
      wr(3'd2, 8'(v));
      chk("R1 readback", bus_rdata, v);
      pins_chk(8'(v));
    end

    // R1: other addresses
    wr(3'd2, 8'h5A);
    for (int a = 0; a < 8; a++) begin
      if (a != 2) begin
        wr(3'(a), 8'hA5);
        bus_addr = 3'(a);
        #1;
        chk("R1 other-address read", bus_rdata, 0);
        bus_addr = 3'd2;
        #1;
        chk("R1 other-address write ignored", bus_rdata, 8'h5A);
      end
    end

    // R4..R7: sweep mode x direction bit x access type
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int r = 0; r < 2; r++) begin
          int exp_oe;
          wr(3'd2, d ? 8'h60 : 8'h40);
          mode_sel    = 3'(m);
          epp_is_read = r[0];
          #1;
          if (m == 0 || m == 2) begin
            exp_oe = 1;
            chk("R5 unidirectional", data_oe, exp_oe);
          end else if (m == 1 || m == 3) begin
            exp_oe = 1 - d;
            chk("R4 dir bit", data_oe, exp_oe);
          end else if (m == 4) begin
            exp_oe = 1 - r;
            chk("R6 epp access", data_oe, exp_oe);
          end else begin
            exp_oe = 0;
            chk("R7 reserved modes", data_oe, exp_oe);
          end
        end
      end
    end
    mode_sel = 3'b000;
    epp_is_read = 1'b0;

    // R8: disabled edge not recorded, also after enabling later
    wr(3'd2, 8'h40);
    ack_pulse();
    cyc(5);
    chk("R8 edge while disabled", irq_status[0], 0);
    wr(3'd2, 8'h50);
    cyc(4);
    chk("R8 no late record", irq_status[0], 0);

    // R8: falling edge alone does nothing
    ack_n_in = 1'b0;
    cyc(5);
    chk("R8 falling edge", irq_status[0], 0);

    // R8: rising edge with enable, latency three edges
    ack_n_in = 1'b1;
    cyc(2);
    chk("R8 before third edge", irq_status[0], 0);
    cyc(1);
    chk("R8 set on third edge", irq_status[0], 1);
    chk("R11 irq_out ack", irq_out, 1);

    // R10: sticky, then clear
    cyc(5);
    chk("R10 ack sticky", irq_status[0], 1);
    irq_clr = 2'b01;
    cyc(1);
    irq_clr = 2'b00;
    chk("R10 ack cleared", irq_status[0], 0);
    chk("R11 irq_out idle", irq_out, 0);

    // R9: masked time-out ignored
    epp_timeout = 1'b1;
    cyc(1);
    epp_timeout = 1'b0;
    cyc(2);
    chk("R9 masked timeout", irq_status[1], 0);

    // R9: unmasked time-out
    wr(3'd2, 8'h00);
    epp_timeout = 1'b1;
    cyc(1);
    epp_timeout = 1'b0;
    chk("R9 unmasked timeout", irq_status[1], 1);
    chk("R11 irq_out timeout", irq_out, 1);

    // R10: clear of other bit leaves it
    irq_clr = 2'b01;
    cyc(1);
    irq_clr = 2'b00;
    chk("R10 clear selects bit", irq_status, 2'b10);

    // R10: set wins over same-cycle clear
    epp_timeout = 1'b1;
    irq_clr = 2'b10;
    cyc(1);
    epp_timeout = 1'b0;
    irq_clr = 2'b00;
    chk("R10 set beats clear", irq_status[1], 1);
    irq_clr = 2'b10;
    cyc(1);
    irq_clr = 2'b00;
    chk("R10 timeout cleared", irq_status, 0);

    // R11: both pending, clear one at a time
    wr(3'd2, 8'h10);
    epp_timeout = 1'b1;
    cyc(1);
    epp_timeout = 1'b0;
    ack_pulse();
    cyc(3);
    chk("R11 both pending", irq_status, 2'b11);
    irq_clr = 2'b10;
    cyc(1);
    irq_clr = 2'b00;
    chk("R11 one left", irq_out, 1);
    irq_clr = 2'b01;
    cyc(1);
    irq_clr = 2'b00;
    chk("R11 none left", irq_out, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule